// File: doc/BRIEF.md
# Two-Input Wormhole Merge Node

This block joins two incoming flit streams into one outgoing stream, as one node of a fan-in tree. Each channel uses two-phase transition signalling with bundled data. A sender places a flit and its last-flit marker on the data pins, then flips its request level. The receiver accepts the flit by flipping its acknowledge level to match. An input is pending while its request level differs from its acknowledge level. The output channel follows the same rule: the output holds a flit while `out_req` differs from `out_ack`.

A grant stage picks one pending input and records that choice as the data select. The single output register then captures the selected flit and flips `out_req`. In the same step the grant is dropped and the winning input's acknowledge is flipped. When a packet's head flit carries last=0, the other input is shut out until the flit with last=1 from the same input has been captured. This keeps multi-flit packets contiguous on the output. When both inputs are pending with no packet open, the tie goes by alternating priority.

Back-pressure comes from the output acknowledge alone. While `out_req != out_ack`, no new grant is made and no input is acknowledged. Each input stays pending until the output drains.

Top module: `wh_merge_node`

## Requirements
- R1: Input k counts as pending exactly when `ink_req != ink_ack`. Each accepted flit flips `ink_ack` once, making it equal to `ink_req`, and a flit that has been acknowledged is never accepted again.
- R2: At most one input is acknowledged per cycle, and each flip of an input acknowledge comes with exactly one output flit.
- R3: A flit is captured only while `out_req == out_ack`. While `out_req != out_ack`, `out_data` and `out_last` hold their value and no input acknowledge flips.
- R4: Take a lone request on an idle node whose output is free. The node flips `out_req` and the input's acknowledge together, at the second rising clock edge after the request flip.
- R5: The data select changes only when a new grant is made, so it changes at most once per flit.
- R6: After a flit with last=0 from input k is captured, the other input is not granted until input k's flit with last=1 has been captured. This holds whether the other request was pending before the lock was set or arrived after it.
- R7: A flit with last=1 that starts a packet sets no lock. After it, the other input can win the very next arbitration.
- R8: When both inputs are pending and no lock is held, the input that was not granted most recently wins. After reset, input 0 wins the first tie.
- R9: Reset clears `out_req`, both input acknowledges, the output data and last bit, the grant and the lock.
- R10: The output carries the winning input's data and last bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in0_req | input | 1 | Input 0 request level (flips once per flit) |
| in0_ack | output | 1 | Input 0 acknowledge level |
| in0_data | input | W | Input 0 flit payload |
| in0_last | input | 1 | Input 0 marker: 1 on the final flit of a packet |
| in1_req | input | 1 | Input 1 request level |
| in1_ack | output | 1 | Input 1 acknowledge level |
| in1_data | input | W | Input 1 flit payload |
| in1_last | input | 1 | Input 1 final-flit marker |
| out_req | output | 1 | Output request level |
| out_ack | input | 1 | Output acknowledge level from the downstream stage |
| out_data | output | W | Output flit payload |
| out_last | output | 1 | Output final-flit marker |

## Verification
The hardest case to reach from the ports is the moment the lock does real work. The packet owner sits idle for a cycle between two of its flits while the rival input is pending and the output is free. Without the lock, the rival would win at that moment. The stimulus reaches it by having a sender flip its next request only after it sees its previous acknowledge. A later case stalls the output acknowledge so that a rival arriving mid-packet and the packet's next flit are pending together, in a tie that the alternating priority would hand to the rival.

// File: rtl/wh_merge_pkg.sv
package wh_merge_pkg;
  typedef enum logic {SRC_A = 1'b0, SRC_B = 1'b1} src_e;

  localparam int unsigned NUM_SRC = 2;

  function automatic src_e peer_of(input src_e s);
    return (s == SRC_A) ? SRC_B : SRC_A;
  endfunction
endpackage

// File: rtl/wh_pend_detect.sv
// Pending test per input (request level differs from acknowledge level),
// with the rival of an open packet masked out.
module wh_pend_detect
  import wh_merge_pkg::*;
#(
  parameter int unsigned N = NUM_SRC
) (
  input  logic [N-1:0] req_lvl,
  input  logic [N-1:0] ack_lvl,
  input  logic         lock_vld,
  input  src_e         lock_src,
  output logic [N-1:0] pend_ok
);
  for (genvar i = 0; i < N; i++) begin : g_src
    localparam logic ME = (i == 1);
    logic pend_raw;
    logic killed;
    assign pend_raw   = req_lvl[i] ^ ack_lvl[i];
    assign killed     = lock_vld & (logic'(lock_src) != ME);
    assign pend_ok[i] = pend_raw & ~killed;
  end
endmodule

// File: rtl/wh_arbiter.sv
// Mutual-exclusion grant with alternating tie priority.
// The select register holds the latest decision between grants.
module wh_arbiter
  import wh_merge_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pend_ok,
  input  logic       out_free,
  input  logic       stored,
  output logic       grant_vld,
  output src_e       sel
);
  src_e prio_q;
  src_e winner;
  logic can_grant;

  always_comb begin
    if (pend_ok == 2'b11)  winner = prio_q;
    else if (pend_ok[1])   winner = SRC_B;
    else                   winner = SRC_A;
  end

  assign can_grant = !grant_vld && out_free && (|pend_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_vld <= 1'b0;
      sel       <= SRC_A;
      prio_q    <= SRC_A;
    end else if (stored) begin
      grant_vld <= 1'b0;
    end else if (can_grant) begin
      grant_vld <= 1'b1;
      sel       <= winner;
      prio_q    <= peer_of(winner);
    end
  end
endmodule

// File: rtl/wh_out_stage.sv
// Single output register with transition-signalling request.
module wh_out_stage
  import wh_merge_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         grant_vld,
  input  src_e         sel,
  input  logic [W-1:0] d_a,
  input  logic [W-1:0] d_b,
  input  logic         l_a,
  input  logic         l_b,
  input  logic         out_ack,
  output logic         out_req,
  output logic [W-1:0] out_data,
  output logic         out_last,
  output logic         out_free,
  output logic         stored,
  output logic         cap_last
);
  logic [W-1:0] mux_data;

  assign mux_data = (sel == SRC_B) ? d_b : d_a;
  assign cap_last = (sel == SRC_B) ? l_b : l_a;
  assign out_free = (out_req == out_ack);
  assign stored   = grant_vld & out_free;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_req  <= 1'b0;
      out_data <= '0;
      out_last <= 1'b0;
    end else if (stored) begin
      out_req  <= ~out_req;
      out_data <= mux_data;
      out_last <= cap_last;
    end
  end
endmodule

// File: rtl/wh_lock_ctl.sv
// Packet lock: opens on a captured flit with last=0, closes on last=1.
module wh_lock_ctl
  import wh_merge_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stored,
  input  logic cap_last,
  input  src_e sel,
  output logic lock_vld,
  output src_e lock_src
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_vld <= 1'b0;
      lock_src <= SRC_A;
    end else if (stored) begin
      lock_vld <= ~cap_last;
      lock_src <= sel;
    end
  end
endmodule

// File: rtl/wh_merge_node.sv
module wh_merge_node
  import wh_merge_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in0_req,
  output logic         in0_ack,
  input  logic [W-1:0] in0_data,
  input  logic         in0_last,
  input  logic         in1_req,
  output logic         in1_ack,
  input  logic [W-1:0] in1_data,
  input  logic         in1_last,
  output logic         out_req,
  input  logic         out_ack,
  output logic [W-1:0] out_data,
  output logic         out_last
);
  logic [NUM_SRC-1:0] req_lvl;
  logic [NUM_SRC-1:0] ack_q;
  logic [NUM_SRC-1:0] pend_ok;
  logic               grant_vld;
  src_e               mux_sel;
  logic               lock_vld;
  src_e               lock_src;
  logic               out_free;
  logic               stored;
  logic               cap_last;

  assign req_lvl = {in1_req, in0_req};
  assign in0_ack = ack_q[0];
  assign in1_ack = ack_q[1];

  wh_pend_detect #(.N(NUM_SRC)) u_pend (
    .req_lvl (req_lvl),
    .ack_lvl (ack_q),
    .lock_vld(lock_vld),
    .lock_src(lock_src),
    .pend_ok (pend_ok)
  );

  wh_arbiter u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend_ok  (pend_ok),
    .out_free (out_free),
    .stored   (stored),
    .grant_vld(grant_vld),
    .sel      (mux_sel)
  );

  wh_out_stage #(.W(W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .grant_vld(grant_vld),
    .sel      (mux_sel),
    .d_a      (in0_data),
    .d_b      (in1_data),
    .l_a      (in0_last),
    .l_b      (in1_last),
    .out_ack  (out_ack),
    .out_req  (out_req),
    .out_data (out_data),
    .out_last (out_last),
    .out_free (out_free),
    .stored   (stored),
    .cap_last (cap_last)
  );

  wh_lock_ctl u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .stored  (stored),
    .cap_last(cap_last),
    .sel     (mux_sel),
    .lock_vld(lock_vld),
    .lock_src(lock_src)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_ack
    localparam logic ME = (i == 1);
    always_ff @(posedge clk) begin
      if (!rst_n)                               ack_q[i] <= 1'b0;
      else if (stored && (logic'(mux_sel) == ME)) ack_q[i] <= ~ack_q[i];
    end
  end
endmodule

// File: rtl/wh_merge_node_chk.sv
module wh_merge_node_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in0_req,
  input logic         in0_ack,
  input logic         in1_req,
  input logic         in1_ack,
  input logic         out_req,
  input logic         out_ack,
  input logic [W-1:0] out_data,
  input logic         out_last,
  input logic         grant_vld,
  input logic         sel,
  input logic         lock_vld,
  input logic         lock_src
);
  // R1: a fresh grant goes only to an input that is pending
  a_r1_grant_pending: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_vld) |-> (sel ? (in1_req != in1_ack) : (in0_req != in0_ack)));

  // R2: never both acknowledges in one cycle
  a_r2_one_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(in0_ack) |-> $stable(in1_ack));

  // R2: every input acknowledge comes with an output flit
  a_r2_ack0_with_out: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(in0_ack) |-> !$stable(out_req));
  a_r2_ack1_with_out: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(in1_ack) |-> !$stable(out_req));

  // R3: capture only into a free output
  a_r3_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_req) |-> $past(out_req == out_ack));

  // R3: held flit does not move
  a_r3_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_req != out_ack) && $stable(out_req)) |-> ($stable(out_data) && $stable(out_last)));

  // R5: select moves only with a new grant
  a_r5_sel_once: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel) |-> $rose(grant_vld));

  // R6: while a packet is open only its owner is granted
  a_r6_lock_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_vld && $rose(grant_vld)) |-> (sel == lock_src));
endmodule

bind wh_merge_node wh_merge_node_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in0_req  (in0_req),
  .in0_ack  (in0_ack),
  .in1_req  (in1_req),
  .in1_ack  (in1_ack),
  .out_req  (out_req),
  .out_ack  (out_ack),
  .out_data (out_data),
  .out_last (out_last),
  .grant_vld(grant_vld),
  .sel      (mux_sel),
  .lock_vld (lock_vld),
  .lock_src (lock_src)
);

// File: tb/wh_merge_node_tb.sv
`timescale 1ns/1ps
module wh_merge_node_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in0_req = 1'b0, in1_req = 1'b0;
  logic         in0_ack, in1_ack;
  logic [W-1:0] in0_data = '0, in1_data = '0;
  logic         in0_last = 1'b0, in1_last = 1'b0;
  logic         out_req;
  logic         out_ack = 1'b0;
  logic [W-1:0] out_data;
  logic         out_last;

  int checks = 0;
  int failures = 0;
  int stall_cyc = 0;
  logic [W:0] exp_q[$];

  always #4 clk = ~clk;

  wh_merge_node #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in0_req(in0_req), .in0_ack(in0_ack), .in0_data(in0_data), .in0_last(in0_last),
    .in1_req(in1_req), .in1_ack(in1_ack), .in1_data(in1_data), .in1_last(in1_last),
    .out_req(out_req), .out_ack(out_ack), .out_data(out_data), .out_last(out_last)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic send(input int port, input logic [W-1:0] d, input logic l);
    @(negedge clk);
    if (port == 0) begin in0_data = d; in0_last = l; in0_req = ~in0_req; end
    else           begin in1_data = d; in1_last = l; in1_req = ~in1_req; end
    @(negedge clk);
    while ((port == 0) ? (in0_ack != in0_req) : (in1_ack != in1_req)) @(negedge clk);
  endtask

  task automatic expect_flit(input logic [W-1:0] d, input logic l);
    exp_q.push_back({l, d});
  endtask

  // scoreboard monitor
  initial begin
    wait (rst_n);
    forever begin
      @(negedge clk);
      if (out_req != out_ack) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected flit", int'({out_last, out_data}), 0);
        end else begin
          logic [W:0] e;
          e = exp_q.pop_front();
          check({out_last, out_data} == e, "R10 flit order/content",
                int'({out_last, out_data}), int'(e));
        end
        repeat (stall_cyc) @(negedge clk);
        out_ack = out_req;
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic a1_prev;
    repeat (4) @(negedge clk);
    // R9 reset state
    check(out_req == 1'b0, "R9 out_req", int'(out_req), 0);
    check(in0_ack == 1'b0 && in1_ack == 1'b0, "R9 acks", int'({in1_ack, in0_ack}), 0);
    check(out_data == '0 && out_last == 1'b0, "R9 out data", int'({out_last, out_data}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4 latency on an idle node, R1 single accept
    expect_flit(8'h11, 1'b1);
    in0_data = 8'h11; in0_last = 1'b1; in0_req = 1'b1;
    @(negedge clk);
    check(out_req == 1'b0 && in0_ack == 1'b0, "R4 early", int'({out_req, in0_ack}), 0);
    @(negedge clk);
    check(out_req == 1'b1 && in0_ack == 1'b1, "R4 second edge", int'({out_req, in0_ack}), 3);
    repeat (4) @(negedge clk);
    check(in0_ack == in0_req, "R1 no repeat accept", int'(in0_ack), int'(in0_req));

    // input 1 alone
    expect_flit(8'h22, 1'b1);
    send(1, 8'h22, 1'b1);

    // R8 tie: last grant was input 1, so input 0 wins
    expect_flit(8'h31, 1'b1); expect_flit(8'h32, 1'b1);
    fork send(0, 8'h31, 1'b1); send(1, 8'h32, 1'b1); join

    // R8 alternation: input 0 alone, then the tie goes to input 1
    expect_flit(8'h41, 1'b1);
    send(0, 8'h41, 1'b1);
    expect_flit(8'h52, 1'b1); expect_flit(8'h51, 1'b1);
    fork send(0, 8'h51, 1'b1); send(1, 8'h52, 1'b1); join

    // R6 rival pending before the lock: packet A on input 0, B on input 1
    expect_flit(8'hA0, 1'b0); expect_flit(8'hA1, 1'b0); expect_flit(8'hA2, 1'b1);
    expect_flit(8'hB0, 1'b1);
    fork
      begin send(0, 8'hA0, 1'b0); send(0, 8'hA1, 1'b0); send(0, 8'hA2, 1'b1); end
      begin @(negedge clk); send(1, 8'hB0, 1'b1); end
    join

    // R6 rival arriving after the lock, with output stalled
    stall_cyc = 6;
    expect_flit(8'hC0, 1'b0); expect_flit(8'hC1, 1'b1); expect_flit(8'hD0, 1'b1);
    fork
      begin send(1, 8'hC0, 1'b0); send(1, 8'hC1, 1'b1); end
      begin
        a1_prev = in1_ack;
        while (in1_ack == a1_prev) @(negedge clk);
        send(0, 8'hD0, 1'b1);
      end
    join
    repeat (20) @(negedge clk);

    // R3 back-pressure: a held flit blocks the next acknowledge
    stall_cyc = 8;
    expect_flit(8'hE0, 1'b1); expect_flit(8'hF1, 1'b1);
    send(0, 8'hE0, 1'b1);
    fork
      send(1, 8'hF1, 1'b1);
      begin
        a1_prev = in1_ack;
        repeat (4) @(negedge clk);
        check(in1_ack == a1_prev, "R3 no ack while full", int'(in1_ack), int'(a1_prev));
        check(out_data == 8'hE0, "R3 data held", int'(out_data), 8'hE0);
      end
    join
    repeat (20) @(negedge clk);
    stall_cyc = 0;

    // R7 single flit sets no lock: after input 1's lone flit, tie goes to input 0
    expect_flit(8'h61, 1'b1);
    send(1, 8'h61, 1'b1);
    expect_flit(8'h70, 1'b1); expect_flit(8'h71, 1'b1);
    fork send(0, 8'h70, 1'b1); send(1, 8'h71, 1'b1); join

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R2 all flits delivered", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule